// File: doc/BRIEF.md
# Dual-Format Instruction Decoder and Issue Sequencer

This block sits between instruction fetch and execute in a small 32-bit RISC core. Each fetched word holds either one full-length instruction or two packed 15-bit compressed instructions. A full word is decoded in one issue slot. A packed word is issued as two slots in order: the upper half first, then the lower half. The fetched word is consumed only when the lower half is accepted downstream. Every slot is expanded into one common decoded form. That form carries the opcode in full-format numbering, the destination, the condition, the operand-B register and the sign-extended immediate.

The block also tests the 3-bit condition against the incoming flags and gives the result as a will-execute bit. It marks the simulator-call and no-operation special instructions and raises illegal-instruction where needed. Whether the simulator call is legal depends on a simulation-present strap. A parameter chooses between two decodes of the top opcode group: floating-point operations, or special instructions. A flush input discards both the pending lower half and the word currently offered.

Top module: `insn_decode_seq`

## Requirements
- R1: When in_word_i[31] is 0, the slot is full format: dst_o = bits 30:27, op_o = bits 26:22, cond_o = bits 21:19, and compressed_o = 0.
- R2: In full format with bit 18 clear, breg_en_o = 0 and imm_o is bits 17:0 sign-extended. With bit 18 set, breg_en_o = 1, breg_o = bits 17:14, and imm_o is bits 13:0 sign-extended.
- R3: The flags are flags_i[0]=Z, [1]=C, [2]=V, [3]=N. The condition codes are:
  - 000: always
  - 001: N^V
  - 010: Z
  - 011: !Z
  - 100: !Z & !(N^V)
  - 101: !(N^V)
  - 110: C
  - 111: V

  will_exec_o is the condition result, ANDed with not-illegal and not-noop.
- R4: When in_word_i[31] is 1, the word is packed. Bits 30:16 issue first with second_o = 0. Bits 14:0 issue next with second_o = 1. in_ready_o rises only in the slot that carries the second half.
- R5: A compressed half is laid out as bits 14:11 destination, 10:8 opcode, 7 operand select, 6:0 operand. Its opcode maps to full numbering as follows: 000→00000 SUB, 001→00001 AND, 010→00010 ADD, 011→10000 CMP, 100→10010 LW, 101→10011 SW, 110→11000 LDI, 111→01101 MOV. cond_o is 000. A packed word with bit 15 set makes both halves illegal.
- R6: For a compressed LDI, imm_o is bits 7:0 sign-extended (-128..127) and there is no register. For other compressed opcodes with bit 7 set, breg_o = bits 6:3 and imm_o is bits 2:0 sign-extended. With bit 7 clear, imm_o is bits 6:0 sign-extended (-64..63).
- R7: A compressed LW or SW with bit 7 clear uses register SP_REG (13) as its base, with breg_en_o = 1.
- R8: With FPU_EN = 0, opcode 11110 sets sim_o. It is illegal when sim_present_i = 0, and sets sim_probe_o when bits 18:0 are zero. Opcode 11111 sets noop_o, is never illegal, and never executes.
- R9: Opcode 11001 is always illegal. With FPU_EN = 0, opcodes 11010 and 11011 are illegal. With FPU_EN = 1, opcodes 11010..11111 set fp_o and are legal, and they are neither SIM nor NOOP.
- R10: While flush_i = 1, out_valid_o = 0 and in_ready_o = 1. Any pending second half is dropped, so the next packed word starts at its first half.
- R11: During reset, and until reset release has passed through two clock edges, out_valid_o = 0 and in_ready_o = 0.
- R12: out_valid_o = in_valid_i & !flush_i. With flush_i low, a slot is accepted only when out_ready_i = 1. A stalled word is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Discard pending half and offered word |
| in_valid_i | input | 1 | Fetched word valid |
| in_word_i | input | 32 | Fetched instruction word |
| in_ready_o | output | 1 | Fetched word consumed |
| flags_i | input | 4 | Flags {N,V,C,Z} |
| sim_present_i | input | 1 | Simulator present strap |
| out_valid_o | output | 1 | Decoded slot valid |
| out_ready_i | input | 1 | Execute accepts slot |
| compressed_o | output | 1 | Slot came from a packed word |
| second_o | output | 1 | Slot is the lower half |
| op_o | output | 5 | Opcode, full numbering |
| dst_o | output | 4 | Destination register |
| cond_o | output | 3 | Condition code |
| breg_en_o | output | 1 | Operand B uses a register |
| breg_o | output | 4 | Operand B register |
| imm_o | output | 32 | Sign-extended immediate |
| will_exec_o | output | 1 | Condition met, legal, not NOOP |
| fp_o | output | 1 | Floating-point operation |
| sim_o | output | 1 | Simulator call |
| noop_o | output | 1 | No-operation |
| sim_probe_o | output | 1 | Simulator-presence probe |
| illegal_o | output | 1 | Illegal instruction |

## Verification
The bench targets the sign-extension boundaries of each immediate form: the 8-bit LDI at -128 and 127, the 7-bit and 3-bit operands, and the 14-bit and 18-bit full immediates. A decoder that takes the wrong sign bit would return large positive values in these cases. It runs every condition against all sixteen flag patterns, so a swapped less-than or greater-than term shows up as a wrong will-execute value. It stalls and flushes in the middle of a packed pair. A design that consumed the word after the first half, or kept the pending half across a flush, would skip an instruction or issue the lower half first. Each of the eight SIM, NOOP and probe combinations is tried under both strap values and both FPU builds.

// File: rtl/idq_pkg.sv
package idq_pkg;
  localparam int WORD_W = 32;
  localparam int XW     = 32;
  localparam int RW     = 4;
  localparam int OPW    = 5;
  localparam int CW     = 3;
  localparam int HW     = 15;

  localparam logic [OPW-1:0] OPC_SUB  = 5'b00000;
  localparam logic [OPW-1:0] OPC_AND  = 5'b00001;
  localparam logic [OPW-1:0] OPC_ADD  = 5'b00010;
  localparam logic [OPW-1:0] OPC_MOV  = 5'b01101;
  localparam logic [OPW-1:0] OPC_CMP  = 5'b10000;
  localparam logic [OPW-1:0] OPC_LW   = 5'b10010;
  localparam logic [OPW-1:0] OPC_SW   = 5'b10011;
  localparam logic [OPW-1:0] OPC_LDI  = 5'b11000;
  localparam logic [OPW-1:0] OPC_RSV  = 5'b11001;
  localparam logic [OPW-1:0] OPC_FPA  = 5'b11010;
  localparam logic [OPW-1:0] OPC_FPB  = 5'b11011;
  localparam logic [OPW-1:0] OPC_SIM  = 5'b11110;
  localparam logic [OPW-1:0] OPC_NOOP = 5'b11111;

  typedef struct packed {
    logic [OPW-1:0] op;
    logic [RW-1:0]  dst;
    logic [CW-1:0]  cond;
    logic           breg_en;
    logic [RW-1:0]  breg;
    logic [XW-1:0]  imm;
    logic           fp;
    logic           sim;
    logic           noop;
    logic           probe;
    logic           illegal;
  } dec_t;
endpackage

// File: rtl/idq_full_dec.sv
module idq_full_dec
  import idq_pkg::*;
#(
  parameter bit FPU_EN = 1'b0
) (
  input  logic [WORD_W-2:0] word_i,
  input  logic              sim_present_i,
  output dec_t              dec_o
);
  logic [OPW-1:0] opc;
  logic           top_grp;

  assign opc     = word_i[26:22];
  assign top_grp = (opc[4:3] == 2'b11) && (opc[2:1] != 2'b00);

  always_comb begin
    dec_o      = '0;
    dec_o.dst  = word_i[30:27];
    dec_o.op   = opc;
    dec_o.cond = word_i[21:19];
    if (word_i[18]) begin
      dec_o.breg_en = 1'b1;
      dec_o.breg    = word_i[17:14];
      dec_o.imm     = {{(XW-14){word_i[13]}}, word_i[13:0]};
    end else begin
      dec_o.imm     = {{(XW-18){word_i[17]}}, word_i[17:0]};
    end
    if (FPU_EN) begin
      dec_o.fp = top_grp;
    end else begin
      dec_o.sim     = (opc == OPC_SIM);
      dec_o.noop    = (opc == OPC_NOOP);
      dec_o.illegal = (opc == OPC_FPA) || (opc == OPC_FPB);
    end
    if (opc == OPC_RSV)
      dec_o.illegal = 1'b1;
    if (dec_o.sim && !sim_present_i)
      dec_o.illegal = 1'b1;
    dec_o.probe = dec_o.sim && (word_i[18:0] == '0);
  end
endmodule

// File: rtl/idq_half_dec.sv
module idq_half_dec
  import idq_pkg::*;
#(
  parameter int SP_REG = 13
) (
  input  logic [HW-1:0] half_i,
  output dec_t          dec_o
);
  localparam logic [RW-1:0] SP_ID = RW'(SP_REG);

  logic [2:0] cop;
  logic       is_mem;

  assign cop    = half_i[10:8];
  assign is_mem = (cop == 3'b100) || (cop == 3'b101);

  always_comb begin
    dec_o     = '0;
    dec_o.dst = half_i[14:11];
    unique case (cop)
      3'b000:  dec_o.op = OPC_SUB;
      3'b001:  dec_o.op = OPC_AND;
      3'b010:  dec_o.op = OPC_ADD;
      3'b011:  dec_o.op = OPC_CMP;
      3'b100:  dec_o.op = OPC_LW;
      3'b101:  dec_o.op = OPC_SW;
      3'b110:  dec_o.op = OPC_LDI;
      default: dec_o.op = OPC_MOV;
    endcase
    if (cop == 3'b110) begin
      dec_o.imm = {{(XW-8){half_i[7]}}, half_i[7:0]};
    end else if (half_i[7]) begin
      dec_o.breg_en = 1'b1;
      dec_o.breg    = half_i[6:3];
      dec_o.imm     = {{(XW-3){half_i[2]}}, half_i[2:0]};
    end else begin
      dec_o.imm = {{(XW-7){half_i[6]}}, half_i[6:0]};
      if (is_mem) begin
        dec_o.breg_en = 1'b1;
        dec_o.breg    = SP_ID;
      end
    end
  end
endmodule

// File: rtl/idq_cond_eval.sv
module idq_cond_eval
  import idq_pkg::*;
(
  input  logic [CW-1:0] cond_i,
  input  logic [3:0]    flags_i,
  output logic          taken_o
);
  logic fz, fc, fv, fn, lt;

  assign fz = flags_i[0];
  assign fc = flags_i[1];
  assign fv = flags_i[2];
  assign fn = flags_i[3];
  assign lt = fn ^ fv;

  always_comb begin
    unique case (cond_i)
      3'b000:  taken_o = 1'b1;
      3'b001:  taken_o = lt;
      3'b010:  taken_o = fz;
      3'b011:  taken_o = !fz;
      3'b100:  taken_o = !fz && !lt;
      3'b101:  taken_o = !lt;
      3'b110:  taken_o = fc;
      default: taken_o = fv;
    endcase
  end
endmodule

// File: rtl/idq_issue_seq.sv
module idq_issue_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic flush_i,
  input  logic in_valid_i,
  input  logic packed_i,
  input  logic out_ready_i,
  output logic live_o,
  output logic pend_o,
  output logic in_ready_o
);
  logic meta_q, live_q;
  logic pend_q, pend_d, pend_en, fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      live_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      live_q <= meta_q;
    end
  end

  always_comb begin
    fire    = live_q && in_valid_i && out_ready_i && !flush_i;
    pend_en = flush_i || !live_q || (fire && packed_i);
    pend_d  = (flush_i || !live_q) ? 1'b0 : !pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend_q <= 1'b0;
    else if (pend_en)
      pend_q <= pend_d;
  end

  assign live_o     = live_q;
  assign pend_o     = pend_q;
  assign in_ready_o = live_q && (flush_i || (out_ready_i && (!packed_i || pend_q)));
endmodule

// File: rtl/insn_decode_seq.sv
module insn_decode_seq
  import idq_pkg::*;
#(
  parameter bit FPU_EN = 1'b0,
  parameter int SP_REG = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_word_i,
  output logic              in_ready_o,
  input  logic [3:0]        flags_i,
  input  logic              sim_present_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              compressed_o,
  output logic              second_o,
  output logic [OPW-1:0]    op_o,
  output logic [RW-1:0]     dst_o,
  output logic [CW-1:0]     cond_o,
  output logic              breg_en_o,
  output logic [RW-1:0]     breg_o,
  output logic [XW-1:0]     imm_o,
  output logic              will_exec_o,
  output logic              fp_o,
  output logic              sim_o,
  output logic              noop_o,
  output logic              sim_probe_o,
  output logic              illegal_o
);
  localparam int NHALF = 2;
  localparam int HSTEP = WORD_W / NHALF;

  logic seq_live, half_pend, packed_w, taken;
  dec_t full_dec, cur;
  dec_t half_dec [NHALF];

  assign packed_w = in_word_i[WORD_W-1];

  idq_issue_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (flush_i),
    .in_valid_i (in_valid_i),
    .packed_i   (packed_w),
    .out_ready_i(out_ready_i),
    .live_o     (seq_live),
    .pend_o     (half_pend),
    .in_ready_o (in_ready_o)
  );

  idq_full_dec #(.FPU_EN(FPU_EN)) u_full (
    .word_i       (in_word_i[WORD_W-2:0]),
    .sim_present_i(sim_present_i),
    .dec_o        (full_dec)
  );

  for (genvar gi = 0; gi < NHALF; gi++) begin : g_half
    idq_half_dec #(.SP_REG(SP_REG)) u_half (
      .half_i(in_word_i[(NHALF-1-gi)*HSTEP +: HW]),
      .dec_o (half_dec[gi])
    );
  end

  always_comb begin
    if (!packed_w) begin
      cur = full_dec;
    end else begin
      cur         = half_pend ? half_dec[1] : half_dec[0];
      cur.illegal = cur.illegal | in_word_i[HW];
    end
  end

  idq_cond_eval u_cond (
    .cond_i (cur.cond),
    .flags_i(flags_i),
    .taken_o(taken)
  );

  assign out_valid_o  = seq_live && in_valid_i && !flush_i;
  assign compressed_o = packed_w;
  assign second_o     = packed_w && half_pend;
  assign op_o         = cur.op;
  assign dst_o        = cur.dst;
  assign cond_o       = cur.cond;
  assign breg_en_o    = cur.breg_en;
  assign breg_o       = cur.breg;
  assign imm_o        = cur.imm;
  assign will_exec_o  = taken && !cur.illegal && !cur.noop;
  assign fp_o         = cur.fp;
  assign sim_o        = cur.sim;
  assign noop_o       = cur.noop;
  assign sim_probe_o  = cur.probe;
  assign illegal_o    = cur.illegal;
endmodule

// File: rtl/idq_checker.sv
module idq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       flush_i,
  input logic       in_valid_i,
  input logic       out_ready_i,
  input logic       sim_present_i,
  input logic       in_ready_o,
  input logic       out_valid_o,
  input logic       compressed_o,
  input logic       second_o,
  input logic [2:0] cond_o,
  input logic       will_exec_o,
  input logic       sim_o,
  input logic       noop_o,
  input logic       illegal_o,
  input logic       half_pend,
  input logic       seq_live
);
  p_flush_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && seq_live) |-> (!out_valid_o && in_ready_o));

  p_flush_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !half_pend);

  p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && !out_ready_i && !flush_i) |-> !in_ready_o);

  p_first_keeps_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && compressed_o && !second_o) |-> !in_ready_o);

  p_first_then_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i && compressed_o && !second_o) |=> half_pend);

  p_noop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    noop_o |-> (!illegal_o && !will_exec_o));

  p_sim_absent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sim_o && !sim_present_i) |-> illegal_o);

  p_always_runs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_o == 3'b000 && !illegal_o && !noop_o) |-> will_exec_o);

  p_half_uncond_r5: assert property (@(posedge clk) disable iff (!rst_n)
    compressed_o |-> (cond_o == 3'b000));
endmodule

bind insn_decode_seq idq_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush_i      (flush_i),
  .in_valid_i   (in_valid_i),
  .out_ready_i  (out_ready_i),
  .sim_present_i(sim_present_i),
  .in_ready_o   (in_ready_o),
  .out_valid_o  (out_valid_o),
  .compressed_o (compressed_o),
  .second_o     (second_o),
  .cond_o       (cond_o),
  .will_exec_o  (will_exec_o),
  .sim_o        (sim_o),
  .noop_o       (noop_o),
  .illegal_o    (illegal_o),
  .half_pend    (half_pend),
  .seq_live     (seq_live)
);

// File: tb/sim_insn_decode_seq.sv
`timescale 1ns/1ps
module sim_insn_decode_seq;
  import idq_pkg::*;

  logic clk = 1'b0;
  logic rst_n, flush, in_valid, out_ready, sim_pres;
  logic [31:0] in_word;
  logic [3:0]  flags;

  logic a_ird, a_ov, a_cmp, a_sec, a_be, a_we, a_fp, a_sim, a_noop, a_prb, a_ill;
  logic [4:0] a_op; logic [3:0] a_dst, a_br; logic [2:0] a_cond; logic [31:0] a_imm;
  logic b_ird, b_ov, b_cmp, b_sec, b_be, b_we, b_fp, b_sim, b_noop, b_prb, b_ill;
  logic [4:0] b_op; logic [3:0] b_dst, b_br; logic [2:0] b_cond; logic [31:0] b_imm;

  int checks = 0, fails = 0;
  logic exp_pend = 1'b0;
  logic last_acc;
  bit   rand_sim = 1'b0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  insn_decode_seq u0 (
    .clk(clk), .rst_n(rst_n), .flush_i(flush), .in_valid_i(in_valid), .in_word_i(in_word),
    .in_ready_o(a_ird), .flags_i(flags), .sim_present_i(sim_pres), .out_valid_o(a_ov),
    .out_ready_i(out_ready), .compressed_o(a_cmp), .second_o(a_sec), .op_o(a_op),
    .dst_o(a_dst), .cond_o(a_cond), .breg_en_o(a_be), .breg_o(a_br), .imm_o(a_imm),
    .will_exec_o(a_we), .fp_o(a_fp), .sim_o(a_sim), .noop_o(a_noop),
    .sim_probe_o(a_prb), .illegal_o(a_ill));

  insn_decode_seq #(.FPU_EN(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .flush_i(flush), .in_valid_i(in_valid), .in_word_i(in_word),
    .in_ready_o(b_ird), .flags_i(flags), .sim_present_i(sim_pres), .out_valid_o(b_ov),
    .out_ready_i(out_ready), .compressed_o(b_cmp), .second_o(b_sec), .op_o(b_op),
    .dst_o(b_dst), .cond_o(b_cond), .breg_en_o(b_be), .breg_o(b_br), .imm_o(b_imm),
    .will_exec_o(b_we), .fp_o(b_fp), .sim_o(b_sim), .noop_o(b_noop),
    .sim_probe_o(b_prb), .illegal_o(b_ill));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h word=%h", tag, act, exp, in_word);
    end
  endtask

  function automatic dec_t ref_dec(logic [31:0] w, logic sec, logic simp, bit fpu);
    dec_t d;
    logic [14:0] h;
    d = '0;
    if (!w[31]) begin
      d.dst = w[30:27]; d.op = w[26:22]; d.cond = w[21:19];
      if (w[18]) begin
        d.breg_en = 1'b1; d.breg = w[17:14]; d.imm = 32'($signed(w[13:0]));
      end else d.imm = 32'($signed(w[17:0]));
      if (fpu) d.fp = (d.op >= 5'd26);
      else begin d.sim = (d.op == 5'd30); d.noop = (d.op == 5'd31); end
      d.illegal = (d.op == 5'd25) || (!fpu && (d.op == 5'd26 || d.op == 5'd27)) || (d.sim && !simp);
      d.probe = d.sim && (w[18:0] == 19'd0);
    end else begin
      h = sec ? w[14:0] : w[30:16];
      d.dst = h[14:11];
      case (h[10:8])
        3'd0: d.op = 5'd0;  3'd1: d.op = 5'd1;  3'd2: d.op = 5'd2;  3'd3: d.op = 5'd16;
        3'd4: d.op = 5'd18; 3'd5: d.op = 5'd19; 3'd6: d.op = 5'd24; default: d.op = 5'd13;
      endcase
      if (h[10:8] == 3'd6) d.imm = 32'($signed(h[7:0]));
      else if (h[7]) begin d.breg_en = 1'b1; d.breg = h[6:3]; d.imm = 32'($signed(h[2:0])); end
      else begin
        d.imm = 32'($signed(h[6:0]));
        if (h[10:8] == 3'd4 || h[10:8] == 3'd5) begin d.breg_en = 1'b1; d.breg = 4'd13; end
      end
      d.illegal = w[15];
    end
    return d;
  endfunction

  function automatic logic ref_exec(dec_t d, logic [3:0] f);
    logic z, c, v, n, t;
    z = f[0]; c = f[1]; v = f[2]; n = f[3];
    case (d.cond)
      3'd0: t = 1'b1;      3'd1: t = n ^ v;  3'd2: t = z;        3'd3: t = !z;
      3'd4: t = !z && (n == v); 3'd5: t = (n == v); 3'd6: t = c; default: t = v;
    endcase
    return t && !d.illegal && !d.noop;
  endfunction

  task automatic step();
    dec_t e0, e1;
    logic ev, er, sec;
    logic [14:0] h;
    string tb;
    @(negedge clk);
    last_acc = 1'b0;
    if (!rst_n) begin
      chk("R11 out_valid in reset", {63'd0, a_ov}, 64'd0);
      chk("R11 in_ready in reset", {63'd0, a_ird}, 64'd0);
    end else begin
      ev = in_valid && !flush;
      er = flush || (out_ready && (!in_word[31] || exp_pend));
      chk(flush ? "R10 out_valid" : "R12 out_valid", {63'd0, a_ov}, {63'd0, ev});
      chk(flush ? "R10 in_ready" : (in_word[31] ? "R4 in_ready" : "R12 in_ready"),
          {63'd0, a_ird}, {63'd0, er});
      if (ev) begin
        sec = in_word[31] && exp_pend;
        h = sec ? in_word[14:0] : in_word[30:16];
        e0 = ref_dec(in_word, sec, sim_pres, 1'b0);
        e1 = ref_dec(in_word, sec, sim_pres, 1'b1);
        chk("R4 half select", {62'd0, a_cmp, a_sec}, {62'd0, in_word[31], sec});
        chk(in_word[31] ? "R5 op/dst/cond" : "R1 op/dst/cond",
            {52'd0, a_op, a_dst, a_cond}, {52'd0, e0.op, e0.dst, e0.cond});
        if (!in_word[31]) tb = "R2 operand B";
        else if (!h[7] && (h[10:8] == 3'd4 || h[10:8] == 3'd5)) tb = "R7 stack base";
        else tb = "R6 compressed operand";
        chk(tb, {27'd0, a_be, a_br, a_imm}, {27'd0, e0.breg_en, e0.breg, e0.imm});
        chk("R8 special flags", {59'd0, a_sim, a_noop, a_prb, a_ill, a_fp},
            {59'd0, e0.sim, e0.noop, e0.probe, e0.illegal, e0.fp});
        chk("R3 will_execute", {63'd0, a_we}, {63'd0, ref_exec(e0, flags)});
        chk("R9 FPU build decode", {57'd0, b_op, b_fp, b_sim, b_noop, b_ill, b_we},
            {57'd0, e1.op, e1.fp, e1.sim, e1.noop, e1.illegal, ref_exec(e1, flags)});
      end
      last_acc = in_valid && er;
    end
    @(posedge clk);
    if (!rst_n || flush) exp_pend = 1'b0;
    else if (in_valid && out_ready && in_word[31]) exp_pend = !exp_pend;
    #1;
  endtask

  task automatic drive_word(logic [31:0] w, int stall_pct, int fl);
    in_valid = 1'b1; in_word = w; flush = 1'b0;
    for (int n = 0; n < 64; n++) begin
      out_ready = (($urandom % 100) >= stall_pct);
      flags = (fl < 0) ? 4'($urandom) : 4'(fl);
      if (rand_sim) sim_pres = 1'($urandom);
      step();
      if (last_acc) break;
    end
    in_valid = 1'b0;
  endtask

  function automatic logic [14:0] mk_half(logic [2:0] cop, logic sel, logic [6:0] fld);
    return {4'($urandom), cop, sel, fld};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; flush = 1'b0; in_valid = 1'b1; out_ready = 1'b1;
    flags = 4'd0; sim_pres = 1'b0; in_word = 32'h8000_0000;
    #1;
    step(); step();                                  // R11 reset state
    rst_n = 1'b1; in_valid = 1'b0;
    repeat (4) @(posedge clk);
    #1;

    // R1 R2 R8 R9: every full opcode, both operand-B forms
    for (int op = 0; op < 32; op++)
      for (int b = 0; b < 2; b++)
        drive_word({1'b0, 4'($urandom), 5'(op), 3'($urandom), 1'(b), 18'($urandom)}, 30, -1);
    // R2 sign boundaries
    drive_word({1'b0, 4'd3, 5'd2, 3'd0, 1'b0, 18'h20000}, 0, -1);
    drive_word({1'b0, 4'd3, 5'd2, 3'd0, 1'b0, 18'h1FFFF}, 0, -1);
    drive_word({1'b0, 4'd3, 5'd2, 3'd0, 1'b1, 4'd7, 14'h2000}, 0, -1);
    // R3 all conditions against all flag patterns
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 16; f++)
        drive_word({1'b0, 4'd1, 5'd2, 3'(c), 1'b0, 18'd5}, 0, f);
    // R4 R5 R6 R7: compressed opcodes, both operand forms, both halves, stalls
    for (int cop = 0; cop < 8; cop++)
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 3; k++)
          drive_word({1'b1, mk_half(3'(cop), 1'(s), 7'($urandom)), 1'b0,
                      mk_half(3'($urandom), 1'($urandom), 7'($urandom))}, 40, -1);
    // R6 LDI extremes -128 and 127
    drive_word({1'b1, 4'd2, 3'd6, 8'h80, 1'b0, 4'd5, 3'd6, 8'h7F}, 0, -1);
    // R7 stack default with negative offset
    drive_word({1'b1, 4'd1, 3'd4, 1'b0, 7'h40, 1'b0, 4'd1, 3'd5, 1'b0, 7'h3F}, 0, -1);
    // R5 reserved bit 15 set
    drive_word({1'b1, 15'h1234, 1'b1, 15'h0567}, 0, -1);
    // R8 SIM legality and probe, NOOP
    for (int sp = 0; sp < 2; sp++) begin
      sim_pres = 1'(sp);
      drive_word({1'b0, 4'd0, 5'd30, 3'd0, 1'b0, 18'd0}, 0, -1);
      drive_word({1'b0, 4'd0, 5'd30, 3'd0, 1'b0, 18'd9}, 0, -1);
      drive_word({1'b0, 4'd0, 5'd30, 3'd0, 1'b1, 18'd0}, 0, -1);
      drive_word({1'b0, 4'd0, 5'd31, 3'd0, 1'b0, 18'($urandom)}, 0, -1);
    end
    // R10 flush between halves
    in_valid = 1'b1; out_ready = 1'b1; flush = 1'b0;
    in_word = {1'b1, mk_half(3'd2, 1'b0, 7'd9), 1'b0, mk_half(3'd1, 1'b0, 7'd3)};
    step();
    flush = 1'b1; step();
    flush = 1'b0;
    drive_word(in_word, 0, -1);
    // R12 stall holds packed word
    in_valid = 1'b1; out_ready = 1'b0;
    in_word = {1'b1, mk_half(3'd7, 1'b1, 7'd21), 1'b0, mk_half(3'd0, 1'b0, 7'd1)};
    step(); step(); step();
    drive_word(in_word, 0, -1);
    // random mix
    rand_sim = 1'b1;
    for (int i = 0; i < 1500; i++)
      drive_word({$urandom} & 32'hFFFF_7FFF, 25, -1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule